// File: doc/BRIEF.md
# SMBus Alert Responder with Address Arbitration

This block lets a device on a shared SMBus raise an interrupt on a common active-low, open-drain ALERT wire and then identify itself to the host. Fault inputs are captured in a sticky fault register. An alert fires when a fault bit that the enable mask allows goes from clear to set. A bit that stays set cannot raise the alert again.

When the host reads from the alert response address, the block acknowledges only while it is holding ALERT. It then sends its own 7-bit address on SDA. SDA is wired-AND across devices, so every responder checks each bit it sends. A responder that releases SDA for a 1 but sees the line low has lost the arbitration and goes quiet. The lowest address therefore wins. The winner drops its alert and the losers keep theirs for a later round.

A strobe from the main register slave reports that the device was addressed directly. That strobe also drops the alert. SCL and SDA are oversampled on the system clock, and the block drives SDA only through a pull-low enable.

Top module: `smb_alert_arb`

## Requirements
- R1: After reset the fault register, the ALERT pull and the SDA pull are all 0. A fault register bit sets on a 0-to-1 transition of its fault input. It stays set until a one is written to the matching bit of `clear_i`. `fault_o` shows the register.
- R2: ALERT is pulled (`alert_pull_o`=1) only when a fault register bit whose `mask_i` bit is 1 changes from 0 to 1. A newly set bit whose mask bit is 0 leaves ALERT unchanged.
- R3: A fault bit that stays set does not pull ALERT again, even if its input toggles. ALERT is pulled again when a different enabled bit sets, or when the same bit is cleared and then sets again.
- R4: A read header byte 0x19 (address 7'b0001100, R/W=1) is acknowledged, by pulling SDA low in the ninth clock, only while ALERT is pulled. Any other header, or this header without a pending alert, leaves SDA released for the whole transfer.
- R5: After the acknowledge, the block sends its own 7-bit address MSB first, then a 1 as the eighth bit. It releases SDA for the host's ninth bit.
- R6: A bit that the block sends as 1 but samples as 0 loses the arbitration. The block then releases SDA until the next START or STOP and keeps ALERT pulled.
- R7: A block that sends all eight response bits without losing releases ALERT.
- R8: A one-cycle pulse on `addressed_i` releases ALERT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| alert_pull_o | output | 1 | 1 pulls the shared ALERT line low |
| own_addr_i | input | 7 | Own 7-bit slave address |
| fault_i | input | N_FAULT | Fault condition inputs |
| mask_i | input | N_FAULT | Per-bit alert enables |
| clear_i | input | N_FAULT | Write-one-to-clear pulses for the fault register |
| addressed_i | input | 1 | Pulse: device addressed directly by a read or write |
| fault_o | output | N_FAULT | Fault register contents |

## Verification
The bench plays the host, and it can also play a rival responder that shares SDA. The rival tests both losing on the first address bit and winning late, at bit 1. A design that keeps driving after it loses would corrupt the rival's address on the line, and one that drops ALERT after losing would make the rival's pending fault disappear. The bench toggles a fault input that is already set, and it raises a masked fault; a design that detects levels instead of register edges, or ignores the mask, would raise ALERT on either one. The bench also issues the alert response read with no pending alert and sends a header for a different address. A design that acknowledges either one would pull the acknowledge bit low.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  localparam logic [6:0] ARA_ADDR = 7'b0001100;
  localparam logic [7:0] ARA_RD   = {ARA_ADDR, 1'b1};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_SEND,
    ST_WAIT
  } resp_st_e;
endpackage

// File: rtl/smb_alert_sync.sv
module smb_alert_sync #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_LEN - 1;

  logic [MSB:0] scl_ff, sda_ff;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[MSB-1:0], scl_i};
      sda_ff <= {sda_ff[MSB-1:0], sda_i};
      scl_d  <= scl_ff[MSB];
      sda_d  <= sda_ff[MSB];
    end
  end

  assign scl_s = scl_ff[MSB];
  assign sda_s = sda_ff[MSB];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_alert_faults.sv
module smb_alert_faults #(
  parameter int N_FAULT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FAULT-1:0] fault_i,
  input  logic [N_FAULT-1:0] mask_i,
  input  logic [N_FAULT-1:0] clear_i,
  input  logic               addressed_i,
  input  logic               win_i,
  output logic [N_FAULT-1:0] fault_o,
  output logic               alert_o
);
  logic [N_FAULT-1:0] fault_d_q, fault_q, fault_prev_q, rise_w;
  logic new_w, alert_q;

  assign rise_w = fault_i & ~fault_d_q;
  // enabled register bit that went 0->1 since last cycle
  assign new_w  = |(fault_q & ~fault_prev_q & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_d_q    <= '0;
      fault_q      <= '0;
      fault_prev_q <= '0;
      alert_q      <= 1'b0;
    end else begin
      fault_d_q    <= fault_i;
      fault_q      <= (fault_q & ~clear_i) | rise_w;
      fault_prev_q <= fault_q;
      if (new_w)                    alert_q <= 1'b1;
      else if (win_i | addressed_i) alert_q <= 1'b0;
    end
  end

  assign fault_o = fault_q;
  assign alert_o = alert_q;

  a_r2_alert_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_q) |-> $past(|(fault_q & ~fault_prev_q & mask_i)));

  a_r1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clear_i & ~rise_w)) |=> ((fault_q & $past(clear_i & ~rise_w)) == '0));

  a_r1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i == '0) |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

  a_r8_addressed_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addressed_i && !new_w) |=> !alert_q);

  a_r7_win_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i && !new_w) |=> !alert_q);
endmodule

// File: rtl/smb_alert_resp.sv
module smb_alert_resp
  import smb_alert_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       alert_i,
  input  logic [6:0] own_addr_i,
  output logic       sda_pull_o,
  output logic       win_o
);
  resp_st_e   state_q;
  logic [7:0] shift_q;
  logic [3:0] cnt_q;
  logic       pull_q, lost_q, win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
      lost_q  <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      win_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
        lost_q  <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
        lost_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              shift_q <= {shift_q[6:0], sda_i};
              cnt_q   <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (shift_q == ARA_RD && alert_i) begin
                pull_q  <= 1'b1;
                state_q <= ST_ACK;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              shift_q <= {own_addr_i, 1'b1};
              pull_q  <= ~own_addr_i[6];
              cnt_q   <= '0;
              state_q <= ST_SEND;
            end
          end
          ST_SEND: begin
            if (scl_rise_i) begin
              if (!pull_q && !sda_i) begin
                lost_q  <= 1'b1;
                pull_q  <= 1'b0;
                state_q <= ST_WAIT;
              end else begin
                cnt_q <= cnt_q + 4'd1;
              end
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                pull_q  <= 1'b0;
                win_q   <= 1'b1;
                state_q <= ST_WAIT;
              end else begin
                shift_q <= {shift_q[6:0], 1'b0};
                pull_q  <= ~shift_q[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign win_o      = win_q;

  a_r4_ack_needs_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && $past(state_q) == ST_ADDR) |-> $past(alert_i));

  a_r6_lost_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |-> !sda_pull_o);

  a_r5_pull_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> (state_q == ST_ACK || state_q == ST_SEND));

  a_r7_win_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q |=> !win_q);
endmodule

// File: rtl/smb_alert_arb.sv
module smb_alert_arb #(
  parameter int N_FAULT  = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic               alert_pull_o,
  input  logic [6:0]         own_addr_i,
  input  logic [N_FAULT-1:0] fault_i,
  input  logic [N_FAULT-1:0] mask_i,
  input  logic [N_FAULT-1:0] clear_i,
  input  logic               addressed_i,
  output logic [N_FAULT-1:0] fault_o
);
  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic alert_w, win_w;

  smb_alert_sync #(.SYNC_LEN(SYNC_LEN)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  smb_alert_faults #(.N_FAULT(N_FAULT)) i_faults (
    .clk_i, .rst_ni, .fault_i, .mask_i, .clear_i, .addressed_i,
    .win_i(win_w), .fault_o, .alert_o(alert_w)
  );

  smb_alert_resp i_resp (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c), .alert_i(alert_w), .own_addr_i,
    .sda_pull_o, .win_o(win_w)
  );

  assign alert_pull_o = alert_w;
endmodule

// File: tb/test_smb_alert_arb.sv
module test_smb_alert_arb;
  localparam int NF = 8;
  localparam int Q  = 10;
  localparam logic [6:0] OWN = 7'h45;

  typedef struct { string req; int val; } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic host_pull = 1'b0, rival_pull = 1'b0, rival_lost = 1'b0;
  logic sda_line, sda_pull, alert_pull, addressed = 1'b0;
  logic [NF-1:0] fault = '0, mask = 8'b0000_0011, clear = '0, fault_rd;
  int n_chk = 0, n_fail = 0;
  item_t exp_q[$];
  int    act_q[$];

  always #10 clk = ~clk;

  assign sda_line = ~(host_pull | rival_pull | sda_pull);

  smb_alert_arb #(.N_FAULT(NF)) i_smb_alert_arb (
    .clk_i(clk), .rst_ni, .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .alert_pull_o(alert_pull), .own_addr_i(OWN), .fault_i(fault), .mask_i(mask),
    .clear_i(clear), .addressed_i(addressed), .fault_o(fault_rd)
  );

  // monitor: pops observations and compares with the expected queue
  always @(negedge clk) begin
    while (act_q.size() != 0) begin
      item_t e;
      int a;
      a = act_q.pop_front();
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected item: actual %0d expected none", a);
      end else begin
        e = exp_q.pop_front();
        if (a != e.val) begin
          n_fail++;
          $display("FAIL %s: actual %0d expected %0d", e.req, a, e.val);
        end
      end
    end
  end

  task automatic expect_item(input string req, input int val);
    exp_q.push_back('{req, val});
  endtask

  task automatic chk(input string req, input int act, input int exp);
    expect_item(req, exp);
    act_q.push_back(act);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic hlow, input logic rv_en, input logic rv_bit,
                           output logic seen);
    host_pull  = hlow;
    rival_pull = rv_en && !rv_bit && !rival_lost;
    wait_n(Q);
    scl = 1'b1;
    wait_n(Q);
    seen = sda_line;
    if (rv_en && rv_bit && !seen) rival_lost = 1'b1;
    wait_n(Q);
    scl = 1'b0;
    wait_n(Q);
  endtask

  function automatic logic [8:0] resp_exp(input logic dut_on, input logic riv_on,
                                          input logic [6:0] riv);
    logic [7:0] d8, r8, bits;
    logic da, ra, line;
    d8 = {OWN, 1'b1};
    r8 = {riv, 1'b1};
    da = dut_on;
    ra = riv_on;
    for (int i = 7; i >= 0; i--) begin
      line = (da ? d8[i] : 1'b1) & (ra ? r8[i] : 1'b1);
      if (da && d8[i] && !line) da = 1'b0;
      if (ra && r8[i] && !line) ra = 1'b0;
      bits[i] = line;
    end
    return {~(dut_on | riv_on), bits};
  endfunction

  task automatic ara_read(input string req, input logic [7:0] hdr, input logic riv_on,
                          input logic [6:0] riv, input logic [8:0] exp);
    logic seen;
    logic [7:0] r8;
    r8 = {riv, 1'b1};
    rival_lost = 1'b0;
    host_pull = 1'b1; wait_n(Q);
    scl = 1'b0; wait_n(Q);
    for (int i = 7; i >= 0; i--) bit_cycle(~hdr[i], 1'b0, 1'b1, seen);
    bit_cycle(1'b0, riv_on, 1'b0, seen);
    chk({req, " ack"}, seen, exp[8]);
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b0, riv_on, r8[i], seen);
      chk($sformatf("%s bit%0d", req, i), seen, exp[i]);
    end
    bit_cycle(1'b0, 1'b0, 1'b1, seen);
    rival_pull = 1'b0;
    host_pull = 1'b1; wait_n(Q);
    scl = 1'b1; wait_n(Q);
    host_pull = 1'b0; wait_n(2*Q);
  endtask

  task automatic fault_edge(input int b);
    fault[b] = 1'b0; wait_n(4);
    fault[b] = 1'b1; wait_n(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(3);
    // R1 reset state
    chk("R1 reset alert", alert_pull, 0);
    chk("R1 reset sda", sda_pull, 0);
    chk("R1 reset faults", fault_rd, 0);
    // R4 no alert pending: no ack
    ara_read("R4 idle", 8'h19, 1'b0, 7'h0, resp_exp(1'b0, 1'b0, 7'h0));
    // R1/R2 enabled fault raises alert
    fault_edge(0);
    chk("R1 set", fault_rd, 8'h01);
    chk("R2 alert", alert_pull, 1);
    // R4 other header not acknowledged
    ara_read("R4 other hdr", {OWN, 1'b1}, 1'b0, 7'h0, resp_exp(1'b0, 1'b0, 7'h0));
    chk("R4 alert kept", alert_pull, 1);
    // R5 own address, R7 release
    ara_read("R5 resp", 8'h19, 1'b0, 7'h0, resp_exp(1'b1, 1'b0, 7'h0));
    chk("R7 released", alert_pull, 0);
    // R3 persisting bit toggled: no re-alert
    fault_edge(0);
    chk("R3 no realert", alert_pull, 0);
    chk("R3 still set", fault_rd, 8'h01);
    // R2 masked bit sets but no alert
    fault_edge(2);
    chk("R2 masked reg", fault_rd, 8'h05);
    chk("R2 masked alert", alert_pull, 0);
    // R3 different enabled bit
    fault_edge(1);
    chk("R3 new bit", alert_pull, 1);
    // R8 addressed strobe
    addressed = 1'b1; wait_n(1); addressed = 1'b0; wait_n(3);
    chk("R8 addressed", alert_pull, 0);
    // R1 clear then R3 re-set alerts again
    clear = 8'h01; wait_n(1); clear = '0; wait_n(3);
    chk("R1 clear", fault_rd, 8'h06);
    fault_edge(0);
    chk("R3 reset and reset", alert_pull, 1);
    // R6 rival with lower address wins
    ara_read("R6 lose", 8'h19, 1'b1, 7'h21, resp_exp(1'b1, 1'b1, 7'h21));
    chk("R6 alert kept", alert_pull, 1);
    chk("R6 sda released", sda_pull, 0);
    // R7 rival with higher address loses late
    ara_read("R7 win", 8'h19, 1'b1, 7'h47, resp_exp(1'b1, 1'b1, 7'h47));
    chk("R7 win release", alert_pull, 0);
    wait_n(5);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule